// File: doc/BRIEF.md
# Address Sequence Command Detector

This block sits beside an asynchronous SRAM-style memory port and watches the accesses that reach it. For every completed access the bus front end gives one synchronous strobe, together with the sampled chip enable, write enable and a 17-bit address. The detector looks for a fixed series of five read addresses. When that series is followed by a sixth read at one of four command addresses, it raises a one-cycle pulse on the matching command output: inhibit automatic store, release that inhibit, STORE, or RECALL.

The detector only observes. Every access it sees, including each one in a command series, is still carried out by the memory as an ordinary read or write. Acting on a command belongs to the logic that consumes the pulses. Matching uses only the low 16 address bits. A write aborts a partial series. A wrong address sends the matcher back to the start, unless that address is itself the opening key, in which case it counts as the first step of a new attempt.

The controller has six states. ST_IDLE means no key has been seen yet. ST_K1 to ST_K5 mean that one to five keys have been matched in order. The transitions are named as follows. Advance moves from ST_IDLE or ST_Kn to the next state when the next expected key is read. Restart goes to ST_K1 when the opening key is read out of turn. Abort goes to ST_IDLE on a write or on any other wrong address. Fire goes from ST_K5 to ST_IDLE on the sixth read and pulses a command if that address is one of the four command addresses. Accesses with chip enable high, and cycles with no strobe, leave the state unchanged.

Top module: `seqcmd_detect`

## Requirements
- R1: After reset all four command outputs are low and the matcher is at its start. A reset in the middle of a series discards the progress made.
- R2: Five strobed reads at 0x4E38, 0xB1C7, 0x83E0, 0x7C1F and 0x703F, in that order, followed by a read at 0x8FC0, pulse cmd_store.
- R3: The same five reads followed by a read at 0x4C63 pulse cmd_recall.
- R4: The same five reads followed by 0x8B45 pulse cmd_inhibit. Followed by 0x4B46 they pulse cmd_release.
- R5: Address bit 16 plays no part in matching. A series with bit 16 set is recognised exactly like one with bit 16 clear.
- R6: A strobed write (chip enable low, write enable low) at any step returns the matcher to the start.
- R7: A strobed read at an unexpected address returns the matcher to the start. If that address is 0x4E38, it counts as the first step of a new series.
- R8: A strobed access with chip enable high neither advances nor resets the matcher.
- R9: A sixth read at an address that is not one of the four command addresses produces no pulse and returns the matcher to the start.
- R10: At most one command output is high at any time, and each pulse lasts exactly one clock cycle.
- R11: Only cycles with the strobe high count as accesses. Address or control changes without a strobe have no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| acc_stb | input | 1 | One-cycle strobe marking a completed bus access |
| ce_n | input | 1 | Chip enable of the access, active low |
| we_n | input | 1 | Write enable of the access, active low |
| addr | input | 17 | Address of the access |
| cmd_inhibit | output | 1 | Pulse: inhibit automatic store |
| cmd_release | output | 1 | Pulse: release the automatic-store inhibit |
| cmd_store | output | 1 | Pulse: STORE command |
| cmd_recall | output | 1 | Pulse: RECALL command |

## Verification
The state register updates on the same clock edge that samples a strobed access. The command pulse is registered from that decision, so it is visible in the cycle after the sixth strobe and gone one cycle later. The bench drives each access at a falling edge, holds the strobe across one rising edge, and samples the outputs at the next falling edge. It compares them with the pulse that the vector expects for that access. Directed tests also sample one further cycle later to confirm that the pulse has ended, and they check that an access made without a strobe changes nothing.

// File: rtl/seqcmd_pkg.sv
package seqcmd_pkg;
    localparam int ADDR_W  = 17;
    localparam int CMP_W   = 16;
    localparam int SEQ_LEN = 5;
    localparam int NCMD    = 4;

    // Command vector bit order: 0 inhibit, 1 release, 2 store, 3 recall
    localparam logic [CMP_W-1:0] SEQ_KEY [SEQ_LEN] = '{
        16'h4E38, 16'hB1C7, 16'h83E0, 16'h7C1F, 16'h703F
    };
    localparam logic [CMP_W-1:0] CMD_KEY [NCMD] = '{
        16'h8B45, 16'h4B46, 16'h8FC0, 16'h4C63
    };

    typedef enum logic [2:0] {
        ST_IDLE = 3'd0,
        ST_K1   = 3'd1,
        ST_K2   = 3'd2,
        ST_K3   = 3'd3,
        ST_K4   = 3'd4,
        ST_K5   = 3'd5
    } seq_state_e;
endpackage

// File: rtl/seqcmd_keymatch.sv
module seqcmd_keymatch
    import seqcmd_pkg::*;
(
    input  logic [CMP_W-1:0]   cmp_addr,
    output logic [SEQ_LEN-1:0] seq_hit,
    output logic [NCMD-1:0]    cmd_hit
);
    for (genvar i = 0; i < SEQ_LEN; i++) begin : g_seq
        assign seq_hit[i] = (cmp_addr == SEQ_KEY[i]);
    end
    for (genvar j = 0; j < NCMD; j++) begin : g_cmd
        assign cmd_hit[j] = (cmp_addr == CMD_KEY[j]);
    end
endmodule

// File: rtl/seqcmd_fsm.sv
module seqcmd_fsm
    import seqcmd_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               acc_stb,
    input  logic               ce_n,
    input  logic               we_n,
    input  logic [SEQ_LEN-1:0] seq_hit,
    input  logic [NCMD-1:0]    cmd_hit,
    output logic [NCMD-1:0]    fire_d
);
    seq_state_e state_q, state_d, restart;

    assign restart = seq_hit[0] ? ST_K1 : ST_IDLE;

    always_comb begin
        state_d = state_q;
        fire_d  = '0;
        if (acc_stb && !ce_n) begin
            if (!we_n) begin
                state_d = ST_IDLE;
            end else begin
                unique case (state_q)
                    ST_IDLE: state_d = seq_hit[0] ? ST_K1 : ST_IDLE;
                    ST_K1:   state_d = seq_hit[1] ? ST_K2 : restart;
                    ST_K2:   state_d = seq_hit[2] ? ST_K3 : restart;
                    ST_K3:   state_d = seq_hit[3] ? ST_K4 : restart;
                    ST_K4:   state_d = seq_hit[4] ? ST_K5 : restart;
                    ST_K5: begin
                        fire_d  = cmd_hit;
                        state_d = (|cmd_hit) ? ST_IDLE : restart;
                    end
                    default: state_d = ST_IDLE;
                endcase
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end
endmodule

// File: rtl/seqcmd_pulse.sv
module seqcmd_pulse
    import seqcmd_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NCMD-1:0] fire_d,
    output logic [NCMD-1:0] cmd_q
);
    always_ff @(posedge clk) begin
        if (!rst_n) cmd_q <= '0;
        else        cmd_q <= fire_d;
    end
endmodule

// File: rtl/seqcmd_detect.sv
module seqcmd_detect
    import seqcmd_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              acc_stb,
    input  logic              ce_n,
    input  logic              we_n,
    input  logic [ADDR_W-1:0] addr,
    output logic              cmd_inhibit,
    output logic              cmd_release,
    output logic              cmd_store,
    output logic              cmd_recall
);
    logic [SEQ_LEN-1:0] seq_hit;
    logic [NCMD-1:0]    cmd_hit;
    logic [NCMD-1:0]    fire_d;
    logic [NCMD-1:0]    cmd_q;
    logic               unused_hi;

    assign unused_hi = ^addr[ADDR_W-1:CMP_W];

    seqcmd_keymatch u_match (
        .cmp_addr (addr[CMP_W-1:0]),
        .seq_hit  (seq_hit),
        .cmd_hit  (cmd_hit)
    );

    seqcmd_fsm u_fsm (
        .clk     (clk),
        .rst_n   (rst_n),
        .acc_stb (acc_stb),
        .ce_n    (ce_n),
        .we_n    (we_n),
        .seq_hit (seq_hit),
        .cmd_hit (cmd_hit),
        .fire_d  (fire_d)
    );

    seqcmd_pulse u_pulse (
        .clk    (clk),
        .rst_n  (rst_n),
        .fire_d (fire_d),
        .cmd_q  (cmd_q)
    );

    assign cmd_inhibit = cmd_q[0];
    assign cmd_release = cmd_q[1];
    assign cmd_store   = cmd_q[2];
    assign cmd_recall  = cmd_q[3];
endmodule

// File: rtl/seqcmd_detect_chk.sv
module seqcmd_detect_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        acc_stb,
    input logic        ce_n,
    input logic        we_n,
    input logic [16:0] addr,
    input logic        cmd_inhibit,
    input logic        cmd_release,
    input logic        cmd_store,
    input logic        cmd_recall
);
    logic [3:0] cmds;
    assign cmds = {cmd_recall, cmd_store, cmd_release, cmd_inhibit};

    a_r10_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(cmds));
    a_r10_single: assert property (@(posedge clk) disable iff (!rst_n)
        (|cmds) |=> !(|cmds));
    a_r6_write_aborts: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_stb && !ce_n && !we_n) |=> !(|cmds));
    a_r8_deselected: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_stb && ce_n) |=> !(|cmds));
    a_r11_no_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        !acc_stb |=> !(|cmds));
    a_r2_store_addr: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_store |-> ($past(addr[15:0]) == 16'h8FC0));
    a_r3_recall_addr: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_recall |-> ($past(addr[15:0]) == 16'h4C63));
    a_r4_inhibit_addr: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_inhibit |-> ($past(addr[15:0]) == 16'h8B45));
    a_r4_release_addr: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_release |-> ($past(addr[15:0]) == 16'h4B46));
endmodule

bind seqcmd_detect seqcmd_detect_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .acc_stb     (acc_stb),
    .ce_n        (ce_n),
    .we_n        (we_n),
    .addr        (addr),
    .cmd_inhibit (cmd_inhibit),
    .cmd_release (cmd_release),
    .cmd_store   (cmd_store),
    .cmd_recall  (cmd_recall)
);

// File: tb/seqcmd_detect_tb.sv
module seqcmd_detect_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        acc_stb = 1'b0;
    logic        ce_n = 1'b1;
    logic        we_n = 1'b1;
    logic [16:0] addr = '0;
    logic        cmd_inhibit, cmd_release, cmd_store, cmd_recall;
    int          checks = 0;
    int          bad = 0;
    bit          done = 1'b0;

    always #10 clk = ~clk;

    seqcmd_detect u_dut (
        .clk(clk), .rst_n(rst_n), .acc_stb(acc_stb), .ce_n(ce_n), .we_n(we_n),
        .addr(addr), .cmd_inhibit(cmd_inhibit), .cmd_release(cmd_release),
        .cmd_store(cmd_store), .cmd_recall(cmd_recall)
    );

    // expected vector order: {recall, store, release, inhibit}
    typedef struct packed {
        logic [3:0]  req;
        logic        ce_n;
        logic        we_n;
        logic [16:0] addr;
        logic [3:0]  exp;
    } vec_t;

    localparam logic [16:0] K0 = 17'h04E38, K1 = 17'h0B1C7, K2 = 17'h083E0,
                            K3 = 17'h07C1F, K4 = 17'h0703F;
    localparam int NV = 61;
    localparam vec_t TBL [NV] = '{
        // R2 store
        '{4'd2,1'b0,1'b1,K0,4'b0000}, '{4'd2,1'b0,1'b1,K1,4'b0000},
        '{4'd2,1'b0,1'b1,K2,4'b0000}, '{4'd2,1'b0,1'b1,K3,4'b0000},
        '{4'd2,1'b0,1'b1,K4,4'b0000}, '{4'd2,1'b0,1'b1,17'h08FC0,4'b0100},
        // R3 recall
        '{4'd3,1'b0,1'b1,K0,4'b0000}, '{4'd3,1'b0,1'b1,K1,4'b0000},
        '{4'd3,1'b0,1'b1,K2,4'b0000}, '{4'd3,1'b0,1'b1,K3,4'b0000},
        '{4'd3,1'b0,1'b1,K4,4'b0000}, '{4'd3,1'b0,1'b1,17'h04C63,4'b1000},
        // R4 inhibit
        '{4'd4,1'b0,1'b1,K0,4'b0000}, '{4'd4,1'b0,1'b1,K1,4'b0000},
        '{4'd4,1'b0,1'b1,K2,4'b0000}, '{4'd4,1'b0,1'b1,K3,4'b0000},
        '{4'd4,1'b0,1'b1,K4,4'b0000}, '{4'd4,1'b0,1'b1,17'h08B45,4'b0001},
        // R5 release with bit 16 set (R4 release path)
        '{4'd5,1'b0,1'b1,17'h14E38,4'b0000}, '{4'd5,1'b0,1'b1,17'h1B1C7,4'b0000},
        '{4'd5,1'b0,1'b1,17'h183E0,4'b0000}, '{4'd5,1'b0,1'b1,17'h17C1F,4'b0000},
        '{4'd5,1'b0,1'b1,17'h1703F,4'b0000}, '{4'd5,1'b0,1'b1,17'h14B46,4'b0010},
        // R6 write aborts
        '{4'd6,1'b0,1'b1,K0,4'b0000}, '{4'd6,1'b0,1'b1,K1,4'b0000},
        '{4'd6,1'b0,1'b0,K2,4'b0000}, '{4'd6,1'b0,1'b1,K2,4'b0000},
        '{4'd6,1'b0,1'b1,K3,4'b0000}, '{4'd6,1'b0,1'b1,K4,4'b0000},
        '{4'd6,1'b0,1'b1,17'h08FC0,4'b0000},
        // R7 opening key out of turn restarts at step one
        '{4'd7,1'b0,1'b1,K0,4'b0000}, '{4'd7,1'b0,1'b1,K1,4'b0000},
        '{4'd7,1'b0,1'b1,K0,4'b0000}, '{4'd7,1'b0,1'b1,K1,4'b0000},
        '{4'd7,1'b0,1'b1,K2,4'b0000}, '{4'd7,1'b0,1'b1,K3,4'b0000},
        '{4'd7,1'b0,1'b1,K4,4'b0000}, '{4'd7,1'b0,1'b1,17'h04C63,4'b1000},
        // R7 wrong address resets
        '{4'd7,1'b0,1'b1,K0,4'b0000}, '{4'd7,1'b0,1'b1,K1,4'b0000},
        '{4'd7,1'b0,1'b1,K2,4'b0000}, '{4'd7,1'b0,1'b1,17'h00000,4'b0000},
        '{4'd7,1'b0,1'b1,K3,4'b0000}, '{4'd7,1'b0,1'b1,K4,4'b0000},
        '{4'd7,1'b0,1'b1,17'h08FC0,4'b0000},
        // R8 deselected accesses are ignored
        '{4'd8,1'b0,1'b1,K0,4'b0000}, '{4'd8,1'b0,1'b1,K1,4'b0000},
        '{4'd8,1'b1,1'b1,17'h01111,4'b0000}, '{4'd8,1'b1,1'b0,17'h00000,4'b0000},
        '{4'd8,1'b0,1'b1,K2,4'b0000}, '{4'd8,1'b0,1'b1,K3,4'b0000},
        '{4'd8,1'b0,1'b1,K4,4'b0000}, '{4'd8,1'b0,1'b1,17'h08B45,4'b0001},
        // R9 unknown sixth address
        '{4'd9,1'b0,1'b1,K0,4'b0000}, '{4'd9,1'b0,1'b1,K1,4'b0000},
        '{4'd9,1'b0,1'b1,K2,4'b0000}, '{4'd9,1'b0,1'b1,K3,4'b0000},
        '{4'd9,1'b0,1'b1,K4,4'b0000}, '{4'd9,1'b0,1'b1,17'h01234,4'b0000},
        '{4'd9,1'b0,1'b1,17'h08FC0,4'b0000}
    };

    function automatic logic [3:0] outs();
        return {cmd_recall, cmd_store, cmd_release, cmd_inhibit};
    endfunction

    task automatic check(input string tag, input logic [3:0] exp);
        checks++;
        if (outs() !== exp) begin
            bad++;
            $display("FAIL %s: cmds=%b expected=%b", tag, outs(), exp);
        end
    endtask

    // called at a falling edge; returns at the falling edge after the strobe
    task automatic access(input logic c, input logic w, input logic [16:0] a);
        ce_n = c; we_n = w; addr = a; acc_stb = 1'b1;
        @(posedge clk);
        @(negedge clk);
        acc_stb = 1'b0;
    endtask

    task automatic prefix();
        access(1'b0, 1'b1, K0); access(1'b0, 1'b1, K1); access(1'b0, 1'b1, K2);
        access(1'b0, 1'b1, K3); access(1'b0, 1'b1, K4);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check("R1 reset", 4'b0000);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 after reset", 4'b0000);

        for (int i = 0; i < NV; i++) begin
            access(TBL[i].ce_n, TBL[i].we_n, TBL[i].addr);
            checks++;
            if (outs() !== TBL[i].exp) begin
                bad++;
                $display("FAIL R%0d vector %0d: cmds=%b expected=%b",
                         TBL[i].req, i, outs(), TBL[i].exp);
            end
        end

        // R10: pulse lasts one cycle
        prefix();
        access(1'b0, 1'b1, 17'h08FC0);
        check("R10 pulse high", 4'b0100);
        @(negedge clk);
        check("R10 pulse gone", 4'b0000);

        // R1: reset mid-series discards progress
        prefix();
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        access(1'b0, 1'b1, 17'h08FC0);
        check("R1 mid-series reset", 4'b0000);

        // R11: accesses without strobe do not count
        access(1'b0, 1'b1, K0); access(1'b0, 1'b1, K1); access(1'b0, 1'b1, K2);
        ce_n = 1'b0; we_n = 1'b0; addr = 17'h00000;
        repeat (3) @(negedge clk);
        check("R11 no strobe write", 4'b0000);
        we_n = 1'b1; addr = 17'h08FC0;
        @(negedge clk);
        @(negedge clk);
        check("R11 no strobe read", 4'b0000);
        access(1'b0, 1'b1, K3); access(1'b0, 1'b1, K4);
        access(1'b0, 1'b1, 17'h08FC0);
        check("R11 series survives idle cycles", 4'b0100);

        // R9: unknown sixth equal to opening key restarts
        prefix();
        access(1'b0, 1'b1, K0);
        check("R9 sixth is opening key", 4'b0000);
        access(1'b0, 1'b1, K1); access(1'b0, 1'b1, K2); access(1'b0, 1'b1, K3);
        access(1'b0, 1'b1, K4);
        access(1'b0, 1'b1, 17'h04C63);
        check("R9 restart completes", 4'b1000);

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", checks, bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            bad++;
            $display("FAIL watchdog: cmds=%b expected=completion", outs());
            $display("test done: total=%0d bad=%0d", checks, bad);
            $finish;
        end
    end
endmodule